// File: doc/BRIEF.md
# Banked Transfer Scheduler with Demand Priority

This block schedules subpage transfers for a memory made of several independent banks. Three kinds of request arrive on a single request port: demand reads, prefetches and copybacks. A fixed rule routes each request to a bank, taken from the low-order bits of its subpage address. Each bank holds its own first-in first-out queue of demand requests, one copyback slot and one prefetch slot, and runs at most one subpage transfer at a time. When a bank is idle it issues one subpage and then waits for its completion pulse.

A background request (prefetch or copyback) covers a run of subpages in its own bank. It starts at a base address and steps by the bank count, so every subpage it issues maps to the same bank. The bank chooses again at every subpage boundary. Pending demand requests always win that choice, so a demand request pre-empts background traffic only between subpages. The interrupted run then continues from its next unfinished subpage once the bank's demand queue is empty. Between the two background kinds, copyback wins. Because each bank makes its own choice, demand traffic in one bank never holds up transfers in another, and background runs in different banks proceed in parallel.

A request is taken only when the target bank has room for it. Otherwise the request port applies back-pressure.

Top module: `bank_xfer_sched`

## Requirements
- R1: A request goes to the bank given by the low log2(NUM_BANKS) bits of `req_addr`, and every issue from bank b carries an address whose low bits equal b.
- R2: Within one bank, demand requests are issued in the order in which they were accepted.
- R3: A bank never issues a new transfer while its previous transfer is still outstanding, so a demand request that arrives during a background subpage waits for that subpage's `done`. Once `done` arrives, a pending demand request is issued before any background subpage.
- R4: A bank that is busy or stalled has no effect on the issue timing or the request acceptance of any other bank.
- R5: A background request with base A and length N issues the addresses A, A+NUM_BANKS, ..., A+(N-1)*NUM_BANKS in that order. If demand requests interleave, the run resumes at its next unissued subpage.
- R6: When a bank is idle and has no demand request pending, a pending copyback subpage is issued before a pending prefetch subpage, even if the prefetch was accepted first.
- R7: `req_ready` is low for a demand request when the target bank's demand queue holds DQ_DEPTH entries, and low for a prefetch or copyback when that bank's slot of the same kind still has subpages left. It is always low for the reserved kind code 2'b11. The kind codes are 2'b00 demand, 2'b01 prefetch and 2'b10 copyback.
- R8: While reset is asserted, and right after it is released, no issue is raised and `req_ready` is high for a demand request.
- R9: A background request with length 0 is accepted, issues nothing, and leaves its slot free.
- R10: `iss_valid[b]` is a single-cycle pulse for each transfer. `iss_kind` carries the kind code of the transfer and `iss_addr` its subpage address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 demand, 01 prefetch, 10 copyback, 11 reserved |
| req_addr | input | ADDR_W | Subpage address (the base address for background runs) |
| req_len | input | LEN_W | Number of subpages in a background run (ignored for demand) |
| req_ready | output | 1 | The target bank can take this request |
| iss_valid | output | NUM_BANKS | Per-bank transfer issue pulse |
| iss_kind | output | 2*NUM_BANKS | Per-bank kind code of the issued transfer |
| iss_addr | output | NUM_BANKS*ADDR_W | Per-bank subpage address of the issued transfer |
| done | input | NUM_BANKS | Per-bank completion pulse of the outstanding transfer |

## Verification
The properties assume that `done[b]` is a one-cycle pulse. It is raised only for a transfer already issued on bank b, never in the same cycle as that bank's issue pulse, and at most once per transfer. They also assume that the request fields stay stable while `req_valid` waits for `req_ready`. The bench meets these assumptions by answering each issue with a single `done` pulse after a per-bank latency of at least one cycle, or by holding `done` off entirely for a stalled bank and releasing it later with one explicit pulse. Requests are driven on the falling edge and held until they are accepted.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

  typedef enum logic [1:0] {
    KIND_DEMAND   = 2'b00,
    KIND_PREFETCH = 2'b01,
    KIND_COPYBACK = 2'b10,
    KIND_RSVD     = 2'b11
  } xfer_kind_e;

endpackage

// File: rtl/bxs_demand_fifo.sv
module bxs_demand_fifo #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic              not_empty,
  output logic              not_full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] store_q [DEPTH];
  logic [PW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign head_addr = store_q[rd_q];
  assign not_empty = (cnt_q != '0);
  assign not_full  = (cnt_q != CW'(DEPTH));

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = step_ptr(wr_q);
    if (pop)  rd_d = step_ptr(rd_q);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store_q[wr_q] <= push_addr;
  end

endmodule

// File: rtl/bxs_bg_slot.sv
module bxs_bg_slot #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 6,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              adv,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              pending
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              upd_en;

  assign cur_addr = base_q;
  assign pending  = (rem_q != '0);
  assign upd_en   = load | adv;

  always_comb begin
    base_d = base_q;
    rem_d  = rem_q;
    if (load) begin
      base_d = load_addr;
      rem_d  = load_len;
    end else if (adv) begin
      base_d = base_q + ADDR_W'(STEP);
      rem_d  = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      rem_q  <= '0;
    end else if (upd_en) begin
      base_q <= base_d;
      rem_q  <= rem_d;
    end
  end

endmodule

// File: rtl/bxs_bank.sv
module bxs_bank
  import bxs_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 6,
  parameter int DQ_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dem_push,
  input  logic              pf_load,
  input  logic              cb_load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              done,
  output logic              dem_rdy,
  output logic              pf_rdy,
  output logic              cb_rdy,
  output logic              iss_valid,
  output logic [1:0]        iss_kind,
  output logic [ADDR_W-1:0] iss_addr
);

  logic [ADDR_W-1:0] dq_head, pf_addr, cb_addr;
  logic              dq_ne, dq_nf, pf_pend, cb_pend;
  logic              launch, dq_pop, pf_adv, cb_adv;
  xfer_kind_e        pick;
  logic [ADDR_W-1:0] pick_addr;

  logic              busy_q, busy_d;
  logic              iss_q, iss_d;
  xfer_kind_e        kind_q;
  logic [ADDR_W-1:0] addr_q;

  bxs_demand_fifo #(.DEPTH(DQ_DEPTH), .ADDR_W(ADDR_W)) u_dq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (dem_push),
    .push_addr (in_addr),
    .pop       (dq_pop),
    .head_addr (dq_head),
    .not_empty (dq_ne),
    .not_full  (dq_nf)
  );

  bxs_bg_slot #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .STEP(NUM_BANKS)) u_pf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pf_load),
    .load_addr (in_addr),
    .load_len  (in_len),
    .adv       (pf_adv),
    .cur_addr  (pf_addr),
    .pending   (pf_pend)
  );

  bxs_bg_slot #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .STEP(NUM_BANKS)) u_cb (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cb_load),
    .load_addr (in_addr),
    .load_len  (in_len),
    .adv       (cb_adv),
    .cur_addr  (cb_addr),
    .pending   (cb_pend)
  );

  assign dem_rdy = dq_nf;
  assign pf_rdy  = !pf_pend;
  assign cb_rdy  = !cb_pend;

  // Choice made only when the bank is idle, i.e. at a subpage boundary.
  always_comb begin
    launch    = 1'b0;
    pick      = KIND_DEMAND;
    pick_addr = dq_head;
    if (!busy_q) begin
      if (dq_ne) begin
        launch    = 1'b1;
        pick      = KIND_DEMAND;
        pick_addr = dq_head;
      end else if (cb_pend) begin
        launch    = 1'b1;
        pick      = KIND_COPYBACK;
        pick_addr = cb_addr;
      end else if (pf_pend) begin
        launch    = 1'b1;
        pick      = KIND_PREFETCH;
        pick_addr = pf_addr;
      end
    end
  end

  assign dq_pop = launch && (pick == KIND_DEMAND);
  assign cb_adv = launch && (pick == KIND_COPYBACK);
  assign pf_adv = launch && (pick == KIND_PREFETCH);

  always_comb begin
    iss_d  = launch;
    busy_d = busy_q;
    if (launch)    busy_d = 1'b1;
    else if (done) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      iss_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      iss_q  <= iss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= KIND_DEMAND;
      addr_q <= '0;
    end else if (launch) begin
      kind_q <= pick;
      addr_q <= pick_addr;
    end
  end

  assign iss_valid = iss_q;
  assign iss_kind  = kind_q;
  assign iss_addr  = addr_q;

endmodule

// File: rtl/bank_xfer_sched.sv
module bank_xfer_sched
  import bxs_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 6,
  parameter int DQ_DEPTH  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [1:0]                  req_kind,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [LEN_W-1:0]            req_len,
  output logic                        req_ready,
  output logic [NUM_BANKS-1:0]        iss_valid,
  output logic [2*NUM_BANKS-1:0]      iss_kind,
  output logic [NUM_BANKS*ADDR_W-1:0] iss_addr,
  input  logic [NUM_BANKS-1:0]        done
);

  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [BANK_W-1:0]    tgt;
  logic [NUM_BANKS-1:0] dem_rdy, pf_rdy, cb_rdy;
  logic                 accept;
  xfer_kind_e           kind_in;

  generate
    if (NUM_BANKS > 1) begin : g_map
      assign tgt = req_addr[BANK_W-1:0];
    end else begin : g_single
      assign tgt = '0;
    end
  endgenerate

  assign kind_in = xfer_kind_e'(req_kind);

  always_comb begin
    case (kind_in)
      KIND_DEMAND:   req_ready = dem_rdy[tgt];
      KIND_PREFETCH: req_ready = pf_rdy[tgt];
      KIND_COPYBACK: req_ready = cb_rdy[tgt];
      default:       req_ready = 1'b0;
    endcase
  end

  assign accept = req_valid && req_ready;

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic hit;
      assign hit = accept && (tgt == BANK_W'(g));

      bxs_bank #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .DQ_DEPTH  (DQ_DEPTH)
      ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .dem_push  (hit && (kind_in == KIND_DEMAND)),
        .pf_load   (hit && (kind_in == KIND_PREFETCH)),
        .cb_load   (hit && (kind_in == KIND_COPYBACK)),
        .in_addr   (req_addr),
        .in_len    (req_len),
        .done      (done[g]),
        .dem_rdy   (dem_rdy[g]),
        .pf_rdy    (pf_rdy[g]),
        .cb_rdy    (cb_rdy[g]),
        .iss_valid (iss_valid[g]),
        .iss_kind  (iss_kind[2*g +: 2]),
        .iss_addr  (iss_addr[g*ADDR_W +: ADDR_W])
      );
    end
  endgenerate

endmodule

// File: rtl/bxs_sched_chk.sv
module bxs_sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [1:0]                  req_kind,
  input logic                        req_ready,
  input logic [NUM_BANKS-1:0]        iss_valid,
  input logic [NUM_BANKS*ADDR_W-1:0] iss_addr,
  input logic [NUM_BANKS-1:0]        done
);

  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [NUM_BANKS-1:0] outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (iss_valid[b])  outst_q[b] <= 1'b1;
        else if (done[b])  outst_q[b] <= 1'b0;
      end
    end
  end

  // R7
  rsvd_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind == 2'b11) |-> !req_ready);

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
      // R10
      iss_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[g] |=> !iss_valid[g]);

      // R3
      single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[g] |-> !outst_q[g]);

      if (NUM_BANKS > 1) begin : g_map
        // R1
        bank_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
          iss_valid[g] |-> (iss_addr[g*ADDR_W +: BANK_W] == BANK_W'(g)));
      end
    end
  endgenerate

endmodule

bind bank_xfer_sched bxs_sched_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_kind  (req_kind),
  .req_ready (req_ready),
  .iss_valid (iss_valid),
  .iss_addr  (iss_addr),
  .done      (done)
);

// File: tb/bank_xfer_sched_test.sv
module bank_xfer_sched_test;

  localparam int NB = 4;
  localparam int AW = 16;
  localparam int LW = 6;
  localparam int DQ = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           req_valid;
  logic [1:0]     req_kind;
  logic [AW-1:0]  req_addr;
  logic [LW-1:0]  req_len;
  logic           req_ready;
  logic [NB-1:0]  iss_valid;
  logic [2*NB-1:0] iss_kind;
  logic [NB*AW-1:0] iss_addr;
  logic [NB-1:0]  done_r;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  int lat [NB];
  int cnt [NB];
  bit outst [NB];
  bit prev_iss [NB];
  int viol_out = 0;
  int viol_pulse = 0;
  int kick_req [NB];
  int kick_ack [NB];
  logic [1:0]    lk [NB][64];
  logic [AW-1:0] la [NB][64];
  int ln [NB];
  int base [NB];

  always #4 clk = ~clk;

  bank_xfer_sched #(.NUM_BANKS(NB), .ADDR_W(AW), .LEN_W(LW), .DQ_DEPTH(DQ)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_ready (req_ready),
    .iss_valid (iss_valid),
    .iss_kind  (iss_kind),
    .iss_addr  (iss_addr),
    .done      (done_r)
  );

  // Completion responder and issue log, all on the falling edge.
  always @(negedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (!rst_n) begin
        done_r[b]   <= 1'b0;
        cnt[b]      = 0;
        outst[b]    = 0;
        prev_iss[b] = 0;
      end else begin
        if (done_r[b]) outst[b] = 0;
        done_r[b] <= 1'b0;
        if (iss_valid[b]) begin
          if (outst[b]) viol_out++;
          if (prev_iss[b]) viol_pulse++;
          if (ln[b] < 64) begin
            lk[b][ln[b]] = iss_kind[2*b +: 2];
            la[b][ln[b]] = iss_addr[b*AW +: AW];
          end
          ln[b]++;
          outst[b] = 1;
          cnt[b] = lat[b];
        end else if (cnt[b] != 0) begin
          cnt[b]--;
          if (cnt[b] == 0) done_r[b] <= 1'b1;
        end
        if (kick_req[b] != kick_ack[b]) begin
          kick_ack[b] = kick_req[b];
          done_r[b] <= 1'b1;
        end
        prev_iss[b] = iss_valid[b];
      end
    end
  end

  task automatic chk_eq(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic submit(logic [1:0] kind, logic [AW-1:0] addr, logic [LW-1:0] len);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = kind;
    req_addr  = addr;
    req_len   = len;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic probe(logic [1:0] kind, logic [AW-1:0] addr, output logic rdy);
    @(negedge clk);
    req_valid = 1'b0;
    req_kind  = kind;
    req_addr  = addr;
    req_len   = 6'd1;
    #1;
    rdy = req_ready;
  endtask

  task automatic snap();
    for (int b = 0; b < NB; b++) base[b] = ln[b];
  endtask

  task automatic chk_entry(string req, int b, int i, logic [1:0] kind, logic [AW-1:0] addr);
    chk_eq(req, $sformatf("bank%0d entry%0d kind", b, i), lk[b][base[b]+i], kind);
    chk_eq(req, $sformatf("bank%0d entry%0d addr", b, i), la[b][base[b]+i], addr);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_kind = 2'b00;
    req_addr = '0;
    req_len = '0;
    repeat (3) @(negedge clk);
    chk_eq("R8", "iss_valid in reset", iss_valid, 0);
    chk_eq("R8", "req_ready in reset", req_ready, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_eq("R8", "iss_valid after reset", iss_valid, 0);
    chk_eq("R8", "req_ready after reset", req_ready, 1);
  endtask

  task automatic t_demand_order();
    snap();
    submit(2'b00, 16'h0011, 6'd0);
    submit(2'b00, 16'h0021, 6'd0);
    submit(2'b00, 16'h0031, 6'd0);
    submit(2'b00, 16'h0102, 6'd0);
    repeat (40) @(negedge clk);
    chk_eq("R2", "bank1 issue count", ln[1] - base[1], 3);
    chk_entry("R2", 1, 0, 2'b00, 16'h0011);
    chk_entry("R2", 1, 1, 2'b00, 16'h0021);
    chk_entry("R2", 1, 2, 2'b00, 16'h0031);
    chk_eq("R1", "bank2 issue count", ln[2] - base[2], 1);
    chk_entry("R1", 2, 0, 2'b00, 16'h0102);
    chk_eq("R1", "bank0 untouched", ln[0] - base[0], 0);
  endtask

  task automatic t_preempt();
    lat[0] = 5;
    snap();
    submit(2'b01, 16'h0100, 6'd3);
    repeat (2) @(negedge clk);
    submit(2'b00, 16'h0200, 6'd0);
    repeat (60) @(negedge clk);
    chk_eq("R5", "bank0 issue count", ln[0] - base[0], 4);
    chk_entry("R3", 0, 0, 2'b01, 16'h0100);
    chk_entry("R3", 0, 1, 2'b00, 16'h0200);
    chk_entry("R5", 0, 2, 2'b01, 16'h0104);
    chk_entry("R5", 0, 3, 2'b01, 16'h0108);
    lat[0] = 2;
  endtask

  task automatic t_independent();
    lat[3] = 0;
    snap();
    submit(2'b10, 16'h0203, 6'd1);
    repeat (5) @(negedge clk);
    submit(2'b00, 16'h0041, 6'd0);
    submit(2'b00, 16'h0013, 6'd0);
    repeat (15) @(negedge clk);
    chk_eq("R4", "bank1 issues beside stalled bank3", ln[1] - base[1], 1);
    chk_entry("R4", 1, 0, 2'b00, 16'h0041);
    chk_eq("R3", "bank3 waits for done", ln[3] - base[3], 1);
    lat[3] = 2;
    @(negedge clk);
    kick_req[3]++;
    repeat (20) @(negedge clk);
    chk_eq("R3", "bank3 after done", ln[3] - base[3], 2);
    chk_entry("R3", 3, 1, 2'b00, 16'h0013);
  endtask

  task automatic t_backpressure();
    logic rdy;
    lat[2] = 0;
    snap();
    submit(2'b00, 16'h0002, 6'd0);
    repeat (4) @(negedge clk);
    submit(2'b00, 16'h0006, 6'd0);
    submit(2'b00, 16'h000A, 6'd0);
    submit(2'b00, 16'h000E, 6'd0);
    submit(2'b00, 16'h0012, 6'd0);
    probe(2'b00, 16'h0016, rdy);
    chk_eq("R7", "demand ready with full queue", rdy, 0);
    submit(2'b01, 16'h0102, 6'd2);
    probe(2'b01, 16'h0202, rdy);
    chk_eq("R7", "prefetch ready with slot held", rdy, 0);
    probe(2'b10, 16'h0302, rdy);
    chk_eq("R7", "copyback ready with slot free", rdy, 1);
    submit(2'b10, 16'h0302, 6'd1);
    probe(2'b10, 16'h0402, rdy);
    chk_eq("R7", "copyback ready with slot held", rdy, 0);
    probe(2'b11, 16'h0001, rdy);
    chk_eq("R7", "reserved kind ready", rdy, 0);
    probe(2'b00, 16'h0005, rdy);
    chk_eq("R4", "bank1 demand ready beside full bank2", rdy, 1);
    lat[2] = 2;
    @(negedge clk);
    kick_req[2]++;
    repeat (80) @(negedge clk);
    chk_eq("R7", "bank2 issue count", ln[2] - base[2], 8);
    chk_entry("R2", 2, 1, 2'b00, 16'h0006);
    chk_entry("R2", 2, 4, 2'b00, 16'h0012);
    chk_entry("R6", 2, 5, 2'b10, 16'h0302);
    chk_entry("R6", 2, 6, 2'b01, 16'h0102);
    chk_entry("R5", 2, 7, 2'b01, 16'h0106);
  endtask

  task automatic t_zero_len();
    logic rdy;
    snap();
    probe(2'b01, 16'h0041, rdy);
    chk_eq("R9", "zero-length ready", rdy, 1);
    submit(2'b01, 16'h0041, 6'd0);
    repeat (20) @(negedge clk);
    chk_eq("R9", "zero-length issues", ln[1] - base[1], 0);
    probe(2'b01, 16'h0041, rdy);
    chk_eq("R9", "slot free after zero-length", rdy, 1);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      lat[b] = 2;
      ln[b] = 0;
      kick_req[b] = 0;
      kick_ack[b] = 0;
    end
    t_reset();
    t_demand_order();
    t_preempt();
    t_independent();
    t_backpressure();
    t_zero_len();
    chk_eq("R3", "overlapping transfers seen", viol_out, 0);
    chk_eq("R10", "issue pulses longer than one cycle", viol_pulse, 0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule